// File: doc/BRIEF.md
# Speculation-Safe Coherence Request Gate

This block sits between a small speculative filter cache and the shared coherence interconnect. Every fill request from the filter cache passes through it. The gate decides whether the request may go out now. A request is held back when it is still speculative and it would take a line away from another core's private cache that holds it Modified or Exclusive. A held request gets a negative acknowledgement. The gate keeps it and sends it again on its own once the owning instruction reaches the head of the queue, because a non-speculative request is never held.

Lines that are granted always enter the filter cache shared. A load that finds no other private copy is tagged as shared-but-exclusive-eligible (SE). Toward the protocol this tag behaves as shared. When such a load commits, the gate fires an exclusive upgrade in the background and does not delay the commit.

A committed store needs ownership. If the core's private cache does not already hold the line exclusive, the gate first broadcasts an invalidation to every other filter cache. It then waits a fixed number of cycles before it reports the upgrade complete, so the wait reveals nothing about which caches held the line.

Top module: `spec_coh_gate`

## Requirements
- R1: If an accepted request has `req_at_head` low and `snp_remote_excl` high, the next cycle shows `nack` high and `fwd_valid` low.
- R2: If an accepted request has `req_at_head` high, the next cycle shows `fwd_valid` high and `nack` low, whatever the snoop inputs are.
- R3: A forwarded load (`req_kind`=0) carries `fwd_fill`=2'b10 (SE) when both `snp_remote_excl` and `snp_remote_shared` are low, and 2'b01 (S) otherwise. In a cycle with no forward, `fwd_fill` is 2'b00.
- R4: A forwarded store (`req_kind`=1) always carries `fwd_fill`=2'b01. It never carries SE.
- R5: A negative acknowledgement sets `retry_pending`. While `retry_pending` is set, `req_ready` is low, and a request offered in that time produces no forward and no `nack`.
- R6: While `retry_pending` is set and `pend_at_head` is high, the next cycle forwards the held request. It uses the held address, sets `fwd_retry` high, computes the fill from the snoop inputs of that cycle, and clears `retry_pending`.
- R7: An accepted commit with `cmt_kind`=0 (SE load) pulses `upg_async` in the next cycle, with `upg_addr` equal to the commit address. `cmt_ready` stays high.
- R8: An accepted store commit (`cmt_kind`=1) with `cmt_local_excl` low pulses `inv_bcast` in the next cycle. During that pulse `inv_mask` has every bit set except bit `SELF_ID`, and it is zero otherwise. `upg_done` pulses exactly `INV_LAT` cycles after `inv_bcast`.
- R9: An accepted store commit with `cmt_local_excl` high pulses `upg_done` in the next cycle, and `inv_bcast` stays low.
- R10: From the `inv_bcast` pulse until the `upg_done` pulse, `cmt_ready` is low, and commits offered in that time have no effect.
- R11: During reset and just after it, every pulse output and `retry_pending` are low, `fwd_fill` is 2'b00, and `req_ready` and `cmt_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Filter-cache fill request offered |
| req_kind | input | 1 | 0 load, 1 store |
| req_addr | input | AW | Line address of the request |
| req_at_head | input | 1 | Requesting instruction is no longer speculative |
| req_ready | output | 1 | Gate accepts a new request |
| snp_remote_excl | input | 1 | Another private cache holds the line M or E |
| snp_remote_shared | input | 1 | Another private cache holds the line shared |
| pend_at_head | input | 1 | Instruction of the held request is now at head |
| retry_pending | output | 1 | A negatively acknowledged request is held |
| fwd_valid | output | 1 | Request sent to the interconnect |
| fwd_addr | output | AW | Address of the forwarded request |
| fwd_fill | output | 2 | Fill tag: 00 none, 01 S, 10 SE |
| fwd_retry | output | 1 | Forward is a replay of a held request |
| nack | output | 1 | Negative acknowledgement to the filter cache |
| cmt_valid | input | 1 | A memory access commits |
| cmt_kind | input | 1 | 0 load of an SE line, 1 store |
| cmt_addr | input | AW | Line address of the commit |
| cmt_local_excl | input | 1 | Own private cache already holds the line exclusive |
| cmt_ready | output | 1 | Gate accepts a commit |
| upg_async | output | 1 | Background exclusive upgrade launched |
| upg_addr | output | AW | Address of the last accepted commit |
| inv_bcast | output | 1 | Invalidation broadcast to peer filter caches |
| inv_mask | output | NC | Peer filter caches targeted by the broadcast |
| upg_done | output | 1 | Ownership upgrade complete |

## Verification
All request and commit results are registered, so `nack`, `fwd_*`, `upg_async`, `inv_bcast` and a local-exclusive `upg_done` are due on the clock edge right after the one that accepts the stimulus. A broadcast `upg_done` is due `INV_LAT` edges after the broadcast pulse. The bench drives inputs on the falling edge. It computes that cycle's expectation before the rising edge and compares one time step after it. It counts broadcast latency in its own model. A separate checker counter in the checker enforces the same latency window.

// File: rtl/scg_pkg.sv
package scg_pkg;

  typedef enum logic [1:0] {
    FILL_NONE = 2'b00,
    FILL_S    = 2'b01,
    FILL_SE   = 2'b10
  } fill_e;

  typedef enum logic {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } req_kind_e;

  typedef enum logic {
    CMT_SE_LOAD = 1'b0,
    CMT_STORE   = 1'b1
  } cmt_kind_e;

  // A speculative request may not demote a remote exclusive holder.
  function automatic logic must_hold(logic at_head, logic remote_excl);
    return remote_excl && !at_head;
  endfunction

  // Filter cache only ever fills shared; a lone load is tagged SE.
  function automatic fill_e grant_fill(req_kind_e kind, logic remote_excl,
                                       logic remote_shared);
    if (kind == KIND_LOAD && !remote_excl && !remote_shared) return FILL_SE;
    return FILL_S;
  endfunction

  // Store commit needs a broadcast unless ownership is already local.
  function automatic logic needs_bcast(cmt_kind_e kind, logic local_excl);
    return (kind == CMT_STORE) && !local_excl;
  endfunction

endpackage

// File: rtl/scg_req_filter.sv
module scg_req_filter
  import scg_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          req_at_head,
  input  logic          snp_remote_excl,
  input  logic          snp_remote_shared,
  input  logic          pend_at_head,
  output logic          req_ready,
  output logic          retry_pending,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [1:0]    fwd_fill,
  output logic          fwd_retry,
  output logic          nack,
  output logic          ev_accept,
  output logic          ev_hold,
  output logic          ev_replay
);

  logic          pend_q;
  logic          pend_kind_q;
  logic [AW-1:0] pend_addr_q;

  assign ev_accept = req_valid && !pend_q;
  assign ev_replay = pend_q && pend_at_head;
  assign ev_hold   = ev_accept && must_hold(req_at_head, snp_remote_excl);

  assign req_ready     = !pend_q;
  assign retry_pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_kind_q <= 1'b0;
      pend_addr_q <= '0;
      fwd_valid   <= 1'b0;
      fwd_addr    <= '0;
      fwd_fill    <= FILL_NONE;
      fwd_retry   <= 1'b0;
      nack        <= 1'b0;
    end else begin
      fwd_valid <= 1'b0;
      fwd_retry <= 1'b0;
      fwd_fill  <= FILL_NONE;
      nack      <= 1'b0;
      if (ev_replay) begin
        fwd_valid <= 1'b1;
        fwd_retry <= 1'b1;
        fwd_addr  <= pend_addr_q;
        fwd_fill  <= grant_fill(req_kind_e'(pend_kind_q), snp_remote_excl,
                                snp_remote_shared);
        pend_q    <= 1'b0;
      end else if (ev_hold) begin
        nack        <= 1'b1;
        pend_q      <= 1'b1;
        pend_kind_q <= req_kind;
        pend_addr_q <= req_addr;
      end else if (ev_accept) begin
        fwd_valid <= 1'b1;
        fwd_addr  <= req_addr;
        fwd_fill  <= grant_fill(req_kind_e'(req_kind), snp_remote_excl,
                                snp_remote_shared);
      end
    end
  end

endmodule

// File: rtl/scg_commit_ctl.sv
module scg_commit_ctl
  import scg_pkg::*;
#(
  parameter int AW      = 16,
  parameter int INV_LAT = 4   // must be at least 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmt_valid,
  input  logic          cmt_kind,
  input  logic [AW-1:0] cmt_addr,
  input  logic          cmt_local_excl,
  output logic          cmt_ready,
  output logic          upg_async,
  output logic          inv_bcast,
  output logic          upg_done,
  output logic [AW-1:0] upg_addr,
  output logic          ev_inv_start,
  output logic          ev_inv_end
);

  localparam int CW = (INV_LAT > 1) ? $clog2(INV_LAT) : 1;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          cmt_take;

  assign cmt_ready    = !busy_q;
  assign cmt_take     = cmt_valid && !busy_q;
  assign ev_inv_start = cmt_take && needs_bcast(cmt_kind_e'(cmt_kind), cmt_local_excl);
  assign ev_inv_end   = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      upg_async <= 1'b0;
      inv_bcast <= 1'b0;
      upg_done  <= 1'b0;
      upg_addr  <= '0;
    end else begin
      upg_async <= 1'b0;
      inv_bcast <= 1'b0;
      upg_done  <= 1'b0;
      if (ev_inv_end) begin
        busy_q   <= 1'b0;
        upg_done <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CW'(1);
      end else if (cmt_take) begin
        upg_addr <= cmt_addr;
        if (cmt_kind_e'(cmt_kind) == CMT_SE_LOAD) begin
          upg_async <= 1'b1;
        end else if (ev_inv_start) begin
          inv_bcast <= 1'b1;
          busy_q    <= 1'b1;
          cnt_q     <= CW'(INV_LAT - 1);
        end else begin
          upg_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spec_coh_gate.sv
module spec_coh_gate #(
  parameter int AW      = 16,
  parameter int NC      = 4,
  parameter int SELF_ID = 1,
  parameter int INV_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          req_at_head,
  output logic          req_ready,
  input  logic          snp_remote_excl,
  input  logic          snp_remote_shared,
  input  logic          pend_at_head,
  output logic          retry_pending,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [1:0]    fwd_fill,
  output logic          fwd_retry,
  output logic          nack,
  input  logic          cmt_valid,
  input  logic          cmt_kind,
  input  logic [AW-1:0] cmt_addr,
  input  logic          cmt_local_excl,
  output logic          cmt_ready,
  output logic          upg_async,
  output logic [AW-1:0] upg_addr,
  output logic          inv_bcast,
  output logic [NC-1:0] inv_mask,
  output logic          upg_done
);

  // Named internal events, brought out for the checker.
  logic ev_accept;
  logic ev_hold;
  logic ev_replay;
  logic ev_inv_start;
  logic ev_inv_end;

  logic [NC-1:0] peer_mask;

  for (genvar g = 0; g < NC; g++) begin : g_peer
    assign peer_mask[g] = (g != SELF_ID);
  end

  assign inv_mask = inv_bcast ? peer_mask : '0;

  scg_req_filter #(.AW(AW)) u_req (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_kind          (req_kind),
    .req_addr          (req_addr),
    .req_at_head       (req_at_head),
    .snp_remote_excl   (snp_remote_excl),
    .snp_remote_shared (snp_remote_shared),
    .pend_at_head      (pend_at_head),
    .req_ready         (req_ready),
    .retry_pending     (retry_pending),
    .fwd_valid         (fwd_valid),
    .fwd_addr          (fwd_addr),
    .fwd_fill          (fwd_fill),
    .fwd_retry         (fwd_retry),
    .nack              (nack),
    .ev_accept         (ev_accept),
    .ev_hold           (ev_hold),
    .ev_replay         (ev_replay)
  );

  scg_commit_ctl #(.AW(AW), .INV_LAT(INV_LAT)) u_cmt (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmt_valid      (cmt_valid),
    .cmt_kind       (cmt_kind),
    .cmt_addr       (cmt_addr),
    .cmt_local_excl (cmt_local_excl),
    .cmt_ready      (cmt_ready),
    .upg_async      (upg_async),
    .inv_bcast      (inv_bcast),
    .upg_done       (upg_done),
    .upg_addr       (upg_addr),
    .ev_inv_start   (ev_inv_start),
    .ev_inv_end     (ev_inv_end)
  );

endmodule

// File: rtl/scg_checker.sv
module scg_checker #(
  parameter int NC      = 4,
  parameter int SELF_ID = 1,
  parameter int INV_LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_kind,
  input logic          req_at_head,
  input logic          req_ready,
  input logic          snp_remote_excl,
  input logic          snp_remote_shared,
  input logic          pend_at_head,
  input logic          retry_pending,
  input logic          fwd_valid,
  input logic [1:0]    fwd_fill,
  input logic          fwd_retry,
  input logic          nack,
  input logic          cmt_valid,
  input logic          cmt_kind,
  input logic          cmt_local_excl,
  input logic          cmt_ready,
  input logic          upg_async,
  input logic          inv_bcast,
  input logic [NC-1:0] inv_mask,
  input logic          upg_done,
  input logic          ev_hold,
  input logic          ev_inv_start
);

  // Cycles since the last broadcast pulse; cleared when the upgrade completes.
  logic [15:0] since_bcast;

  always_ff @(posedge clk) begin
    if (!rst_n)              since_bcast <= '0;
    else if (inv_bcast)      since_bcast <= 16'd1;
    else if (upg_done)       since_bcast <= '0;
    else if (since_bcast != 0) since_bcast <= since_bcast + 16'd1;
  end

  a_r1_spec_demote_nacked: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_at_head && snp_remote_excl |=> nack && !fwd_valid);

  a_r1_hold_event_nacks: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> nack && retry_pending);

  a_r2_head_always_passes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_at_head |=> fwd_valid && !nack);

  a_r3_lone_load_is_se: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_kind && !snp_remote_excl && !snp_remote_shared
    |=> fwd_fill == 2'b10);

  a_r4_store_fills_shared: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind && (req_at_head || !snp_remote_excl)
    |=> fwd_fill == 2'b01);

  a_r5_hold_blocks_intake: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pending |-> !req_ready);

  a_r5_nack_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    nack |-> retry_pending);

  a_r6_replay_on_head: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pending && pend_at_head |=> fwd_valid && fwd_retry && !retry_pending);

  a_r7_async_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && cmt_ready && !cmt_kind |=> upg_async && cmt_ready);

  a_r8_bcast_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_start |=> inv_bcast);

  a_r8_peers_only: assert property (@(posedge clk) disable iff (!rst_n)
    inv_bcast |-> !inv_mask[SELF_ID] && ($countones(inv_mask) == NC - 1));

  a_r8_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    since_bcast != 0 |-> (upg_done == (since_bcast == 16'(INV_LAT))));

  a_r9_local_owner_fast: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && cmt_ready && cmt_kind && cmt_local_excl |=> upg_done && !inv_bcast);

  a_r10_busy_blocks_commit: assert property (@(posedge clk) disable iff (!rst_n)
    inv_bcast |-> !cmt_ready);

endmodule

bind spec_coh_gate scg_checker #(
  .NC(NC), .SELF_ID(SELF_ID), .INV_LAT(INV_LAT)
) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_valid         (req_valid),
  .req_kind          (req_kind),
  .req_at_head       (req_at_head),
  .req_ready         (req_ready),
  .snp_remote_excl   (snp_remote_excl),
  .snp_remote_shared (snp_remote_shared),
  .pend_at_head      (pend_at_head),
  .retry_pending     (retry_pending),
  .fwd_valid         (fwd_valid),
  .fwd_fill          (fwd_fill),
  .fwd_retry         (fwd_retry),
  .nack              (nack),
  .cmt_valid         (cmt_valid),
  .cmt_kind          (cmt_kind),
  .cmt_local_excl    (cmt_local_excl),
  .cmt_ready         (cmt_ready),
  .upg_async         (upg_async),
  .inv_bcast         (inv_bcast),
  .inv_mask          (inv_mask),
  .upg_done          (upg_done),
  .ev_hold           (ev_hold),
  .ev_inv_start      (ev_inv_start)
);

// File: tb/tb_spec_coh_gate.sv
`timescale 1ns/1ps
module tb_spec_coh_gate;

  localparam int AW = 16;
  localparam int NC = 4;
  localparam int SELF_ID = 1;
  localparam int INV_LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_kind = 0, req_at_head = 0;
  logic [AW-1:0] req_addr = '0;
  logic snp_remote_excl = 0, snp_remote_shared = 0, pend_at_head = 0;
  logic cmt_valid = 0, cmt_kind = 0, cmt_local_excl = 0;
  logic [AW-1:0] cmt_addr = '0;
  logic req_ready, retry_pending, fwd_valid, fwd_retry, nack;
  logic [AW-1:0] fwd_addr, upg_addr;
  logic [1:0] fwd_fill;
  logic cmt_ready, upg_async, inv_bcast, upg_done;
  logic [NC-1:0] inv_mask;

  always #2.5 clk = ~clk;

  spec_coh_gate #(.AW(AW), .NC(NC), .SELF_ID(SELF_ID), .INV_LAT(INV_LAT)) dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  // bench model state
  bit m_pend = 0, m_pkind = 0, m_busy = 0;
  logic [AW-1:0] m_paddr = '0, m_uaddr = '0;
  int m_rem = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // 01 = shared, 10 = shared with exclusive upgrade eligibility
  function automatic logic [1:0] exp_fill(bit kind, bit ex, bit sh);
    if (kind) return 2'b01;
    return (ex || sh) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [NC-1:0] exp_mask();
    logic [NC-1:0] m = '1;
    m[SELF_ID] = 1'b0;
    return m;
  endfunction

  task automatic tick();
    bit e_fwd = 0, e_nack = 0, e_rtry = 0, e_kind = 0;
    bit e_async = 0, e_inv = 0, e_done = 0, done_local = 0;
    logic [1:0] e_fill = 2'b00;
    logic [AW-1:0] e_faddr = '0;
    if (m_pend) begin
      if (pend_at_head) begin
        e_fwd = 1; e_rtry = 1; e_faddr = m_paddr; e_kind = m_pkind;
        e_fill = exp_fill(m_pkind, snp_remote_excl, snp_remote_shared);
        m_pend = 0;
      end
    end else if (req_valid) begin
      if (snp_remote_excl && !req_at_head) begin
        e_nack = 1; m_pend = 1; m_paddr = req_addr; m_pkind = req_kind;
      end else begin
        e_fwd = 1; e_faddr = req_addr; e_kind = req_kind;
        e_fill = exp_fill(req_kind, snp_remote_excl, snp_remote_shared);
      end
    end
    if (m_busy) begin
      m_rem--;
      if (m_rem == 0) begin e_done = 1; m_busy = 0; end
    end else if (cmt_valid) begin
      m_uaddr = cmt_addr;
      if (!cmt_kind) e_async = 1;
      else if (cmt_local_excl) begin e_done = 1; done_local = 1; end
      else begin e_inv = 1; m_busy = 1; m_rem = INV_LAT; end
    end
    @(posedge clk);
    #1;
    chk("R1", "nack", nack, e_nack);
    chk("R2", "fwd_valid", fwd_valid, e_fwd);
    if (e_fwd) chk("R2", "fwd_addr", fwd_addr, e_faddr);
    chk(e_kind ? "R4" : "R3", "fwd_fill", fwd_fill, e_fill);
    chk("R5", "retry_pending", retry_pending, m_pend);
    chk("R5", "req_ready", req_ready, !m_pend);
    chk("R6", "fwd_retry", fwd_retry, e_rtry);
    chk("R7", "upg_async", upg_async, e_async);
    chk("R8", "inv_bcast", inv_bcast, e_inv);
    chk("R8", "inv_mask", inv_mask, e_inv ? exp_mask() : '0);
    chk(done_local ? "R9" : "R8", "upg_done", upg_done, e_done);
    chk("R10", "cmt_ready", cmt_ready, !m_busy);
    if (e_async || e_inv || e_done) chk("R7", "upg_addr", upg_addr, m_uaddr);
    @(negedge clk);
  endtask

  task automatic drv(bit rv, bit rk, bit rh, logic [AW-1:0] ra, bit ex, bit sh,
                     bit ph, bit cv, bit ck, logic [AW-1:0] ca, bit cl);
    req_valid = rv; req_kind = rk; req_at_head = rh; req_addr = ra;
    snp_remote_excl = ex; snp_remote_shared = sh; pend_at_head = ph;
    cmt_valid = cv; cmt_kind = ck; cmt_addr = ca; cmt_local_excl = cl;
    tick();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset fwd_valid", fwd_valid, 0);
    chk("R11", "reset nack", nack, 0);
    chk("R11", "reset fill", fwd_fill, 0);
    chk("R11", "reset retry_pending", retry_pending, 0);
    chk("R11", "reset req_ready", req_ready, 1);
    chk("R11", "reset cmt_ready", cmt_ready, 1);
    chk("R11", "reset pulses", {upg_async, inv_bcast, upg_done}, 0);
    @(negedge clk);
    rst_n = 1;
    drv(0,0,0,0,0,0,0,0,0,0,0);                 // R11 idle after reset
    // R1 then R5: speculative load against remote owner, further requests ignored
    drv(1,0,0,16'h0A10,1,0,0,0,0,0,0);
    drv(1,1,1,16'h0B20,0,0,0,0,0,0,0);
    drv(1,0,0,16'h0C30,0,1,0,0,0,0,0);
    // R6: replay at head while the owner still holds it
    drv(0,0,0,0,1,0,1,0,0,0,0);
    // R2: head load against remote owner passes, fill S
    drv(1,0,1,16'h0D40,1,1,0,0,0,0,0);
    // R3: lone load gets SE, shared load gets S
    drv(1,0,0,16'h0E50,0,0,0,0,0,0,0);
    drv(1,0,0,16'h0E58,0,1,0,0,0,0,0);
    // R4: speculative store with no sharers still fills S
    drv(1,1,0,16'h0F60,0,0,0,0,0,0,0);
    // R7, R9, then R8 with R10 blocking commits during the broadcast window
    drv(0,0,0,0,0,0,0,1,0,16'h1111,0);
    drv(0,0,0,0,0,0,0,1,1,16'h2222,1);
    drv(0,0,0,0,0,0,0,1,1,16'h3333,0);
    for (int i = 0; i < INV_LAT + 1; i++) drv(0,0,0,0,0,0,0,1,1,16'h4444,1);
    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      drv(($urandom % 10) < 6, $urandom % 2, ($urandom % 10) < 4, AW'($urandom),
          ($urandom % 4) == 0, ($urandom % 10) < 4, ($urandom % 10) < 3,
          ($urandom % 10) < 3, $urandom % 2, AW'($urandom), $urandom % 2);
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done_flag) begin
      done_flag = 1;
      n_tests++; n_fail++;
      $display("FAIL R6 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule